// File: doc/BRIEF.md
# Channel Fault Latch and Offline Flush

This block holds the status and fault logic for a group of transmit channels. Each channel has an input FIFO and a processing pipeline. Those two sit outside the block and send in their condition flags. Every cycle, each channel captures a 12-bit status word. Several of its bits mark error conditions, and those bits are merged into a sticky per-channel fault bit. The fault bits sit in a shared device-level status word, next to sticky saturation bits for the output summers.

When a FIFO overflow is detected, the channel leaves normal operation. It goes offline and forces the FIFO read address it passes on to zero, so the FIFO sends out zero data. A control input can disable this action. While the channel is offline, a counter counts sample-clock enable pulses. Once enough pulses have gone by for the zeros to clear the pipeline, a flushed bit appears in the status word.

The channel stays offline until that channel is reset. Sticky bits in the device-level word clear only when the host writes to that word.

Top module: `chfault_top`

## Requirements
- R1: While `rst` is high, every channel status word and `top_status` read zero, and each `fifo_raddr_out` slice equals its `fifo_raddr_in` slice.
- R2: One clock edge after its inputs, channel c's status slice `chan_status[12c+11:12c]` has this layout:
  - bit 11: flushed
  - bit 10: FIR overflow
  - bit 9: FIR underflow
  - bit 8: FIFO overflow
  - bit 7: FIFO underflow
  - bits 6:4: the effective (possibly forced) read address
  - bit 3: offline
  - bit 2: almost empty
  - bit 1: empty
  - bit 0: always zero
- R3: If any of status bits 10:7 or bit 3 of channel c is set, `top_status[12+c]` is set one edge later. It then stays set without further cause. The almost-empty and empty bits never set it.
- R4: A clock edge with `fifo_ovf[c]` high and `ovf_halt_dis` low puts channel c offline. From that edge on, `fifo_raddr_out` for channel c reads 0.
- R5: While channel c is offline, its read-address output is 0 whatever `fifo_raddr_in` holds. The status address field then also reads 0.
- R6: The flushed bit (status bit 11) rises one edge after the 24th edge at which the channel was offline and `sample_en` was high. Edges without `sample_en` do not count.
- R7: Offline mode and the flushed bit persist until `ch_rst[c]`. A `ch_rst[c]` edge clears that channel's status word, offline state and counter, and leaves `top_status` unchanged.
- R8: A `top_wr` edge clears every sticky bit of `top_status`. If a fault or saturation cause is present at that same edge, the bit stays set.
- R9: `sum_sat[s]` high at an edge sets `top_status[s]`, which then stays set until cleared by R8.
- R10: With `ovf_halt_dis` high, a FIFO overflow is still reported in status bit 8, but the channel stays online and the read address passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sample-clock enable pulse |
| ovf_halt_dis | input | 1 | Disables offline entry on FIFO overflow |
| ch_rst | input | NUM_CH | Per-channel reset |
| fir_ovf | input | NUM_CH | FIR overflow flag per channel |
| fir_unf | input | NUM_CH | FIR underflow flag per channel |
| fifo_ovf | input | NUM_CH | FIFO overflow flag per channel |
| fifo_unf | input | NUM_CH | FIFO underflow flag per channel |
| fifo_aempty | input | NUM_CH | FIFO almost-empty flag per channel |
| fifo_empty | input | NUM_CH | FIFO empty flag per channel |
| fifo_raddr_in | input | 3*NUM_CH | FIFO read address proposed per channel |
| sum_sat | input | NUM_SUM | Summer saturation flags |
| top_wr | input | 1 | Host write strobe to the device status word |
| fifo_raddr_out | output | 3*NUM_CH | Effective FIFO read address per channel |
| chan_status | output | 12*NUM_CH | Captured status word per channel |
| top_status | output | 16 | Sticky channel faults (15:12) and summer saturation (NUM_SUM-1:0) |

## Verification
The bench counts the flush window exactly. It sends 23 counted pulses, then several edges with no enable, then the 24th pulse. A counter that was off by one, or one that ran on every clock, would raise the flushed bit early.

It applies a clear-on-write while a fault cause is still present. A design that let the clear win would lose an event. A later clear with no cause present then shows the bit does drop.

It overflows a FIFO with the halt disabled, so a design that ignored the disable would force the address to zero. It also checks that a channel reset leaves the sticky fault bits untouched.

// File: rtl/chfault_pkg.sv
package chfault_pkg;

    localparam int STAT_W  = 12;
    localparam int RADDR_W = 3;

    // Flags arriving from the FIFO and pipeline of one channel
    typedef struct packed {
        logic               fir_ovf;
        logic               fir_unf;
        logic               fifo_ovf;
        logic               fifo_unf;
        logic               aempty;
        logic               empty;
        logic [RADDR_W-1:0] raddr;
    } chan_flags_t;

    // Captured status word, MSB first (bit 11 down to bit 0)
    typedef struct packed {
        logic               flushed;   // 11
        logic               fir_ovf;   // 10
        logic               fir_unf;   // 9
        logic               fifo_ovf;  // 8
        logic               fifo_unf;  // 7
        logic [RADDR_W-1:0] raddr;     // 6:4
        logic               offline;   // 3
        logic               aempty;    // 2
        logic               empty;     // 1
        logic               rsvd;      // 0
    } chan_stat_t;

    function automatic chan_stat_t pack_status(chan_flags_t f, logic offline,
                                               logic flushed, logic [RADDR_W-1:0] eff_addr);
        chan_stat_t s;
        s.flushed  = flushed;
        s.fir_ovf  = f.fir_ovf;
        s.fir_unf  = f.fir_unf;
        s.fifo_ovf = f.fifo_ovf;
        s.fifo_unf = f.fifo_unf;
        s.raddr    = eff_addr;
        s.offline  = offline;
        s.aempty   = f.aempty;
        s.empty    = f.empty;
        s.rsvd     = 1'b0;
        return s;
    endfunction

    // Error bits that feed the sticky channel fault
    function automatic logic stat_is_fault(chan_stat_t s);
        return s.fir_ovf | s.fir_unf | s.fifo_ovf | s.fifo_unf | s.offline;
    endfunction

endpackage

// File: rtl/chfault_flush_timer.sv
module chfault_flush_timer #(
    parameter int FLUSH_LEN = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CNT_W = $clog2(FLUSH_LEN + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FLUSH_LEN);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run && tick && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/chfault_sticky_bank.sv
module chfault_sticky_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    // A new cause at the clearing edge survives the clear
    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else begin
            q_r <= (clr ? '0 : q_r) | set;
        end
    end

    assign q = q_r;
endmodule

// File: rtl/chfault_chan.sv
module chfault_chan
    import chfault_pkg::*;
#(
    parameter int FLUSH_LEN = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ch_rst,
    input  logic               sample_en,
    input  logic               halt_dis,
    input  chan_flags_t        flags,
    output logic [RADDR_W-1:0] raddr_out,
    output chan_stat_t         stat_out,
    output logic               fault_evt
);
    logic       offline_q;
    logic       flushed;
    chan_stat_t stat_q;

    always_ff @(posedge clk) begin
        if (rst || ch_rst) begin
            offline_q <= 1'b0;
        end else if (flags.fifo_ovf && !halt_dis) begin
            offline_q <= 1'b1;
        end
    end

    chfault_flush_timer #(.FLUSH_LEN(FLUSH_LEN)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (ch_rst),
        .run  (offline_q),
        .tick (sample_en),
        .done (flushed)
    );

    assign raddr_out = offline_q ? '0 : flags.raddr;

    always_ff @(posedge clk) begin
        if (rst || ch_rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= pack_status(flags, offline_q, flushed, raddr_out);
        end
    end

    assign stat_out  = stat_q;
    assign fault_evt = stat_is_fault(stat_q);
endmodule

// File: rtl/chfault_top.sv
module chfault_top
    import chfault_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_SUM   = 4,
    parameter int TOP_W     = 16,
    parameter int FLUSH_LEN = 24
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sample_en,
    input  logic                      ovf_halt_dis,
    input  logic [NUM_CH-1:0]         ch_rst,
    input  logic [NUM_CH-1:0]         fir_ovf,
    input  logic [NUM_CH-1:0]         fir_unf,
    input  logic [NUM_CH-1:0]         fifo_ovf,
    input  logic [NUM_CH-1:0]         fifo_unf,
    input  logic [NUM_CH-1:0]         fifo_aempty,
    input  logic [NUM_CH-1:0]         fifo_empty,
    input  logic [NUM_CH*RADDR_W-1:0] fifo_raddr_in,
    input  logic [NUM_SUM-1:0]        sum_sat,
    input  logic                      top_wr,
    output logic [NUM_CH*RADDR_W-1:0] fifo_raddr_out,
    output logic [NUM_CH*STAT_W-1:0]  chan_status,
    output logic [TOP_W-1:0]          top_status
);
    localparam int FAULT_LSB = TOP_W - NUM_CH;

    logic [NUM_CH-1:0]  fault_evt;
    logic [NUM_CH-1:0]  fault_q;
    logic [NUM_SUM-1:0] sat_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        chan_flags_t fl;
        chan_stat_t  st;

        assign fl.fir_ovf  = fir_ovf[c];
        assign fl.fir_unf  = fir_unf[c];
        assign fl.fifo_ovf = fifo_ovf[c];
        assign fl.fifo_unf = fifo_unf[c];
        assign fl.aempty   = fifo_aempty[c];
        assign fl.empty    = fifo_empty[c];
        assign fl.raddr    = fifo_raddr_in[c*RADDR_W +: RADDR_W];

        chfault_chan #(.FLUSH_LEN(FLUSH_LEN)) chan_i (
            .clk       (clk),
            .rst       (rst),
            .ch_rst    (ch_rst[c]),
            .sample_en (sample_en),
            .halt_dis  (ovf_halt_dis),
            .flags     (fl),
            .raddr_out (fifo_raddr_out[c*RADDR_W +: RADDR_W]),
            .stat_out  (st),
            .fault_evt (fault_evt[c])
        );

        assign chan_status[c*STAT_W +: STAT_W] = st;
    end

    chfault_sticky_bank #(.W(NUM_CH)) fault_bank_i (
        .clk (clk),
        .rst (rst),
        .set (fault_evt),
        .clr (top_wr),
        .q   (fault_q)
    );

    chfault_sticky_bank #(.W(NUM_SUM)) sat_bank_i (
        .clk (clk),
        .rst (rst),
        .set (sum_sat),
        .clr (top_wr),
        .q   (sat_q)
    );

    always_comb begin
        top_status = '0;
        top_status[FAULT_LSB +: NUM_CH] = fault_q;
        top_status[NUM_SUM-1:0]         = sat_q;
    end
endmodule

// File: rtl/chfault_top_chk.sv
module chfault_top_chk #(
    parameter int NUM_CH  = 4,
    parameter int NUM_SUM = 4,
    parameter int TOP_W   = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ovf_halt_dis,
    input logic [NUM_CH-1:0]     ch_rst,
    input logic [NUM_CH-1:0]     fifo_ovf,
    input logic [NUM_SUM-1:0]    sum_sat,
    input logic                  top_wr,
    input logic [NUM_CH*3-1:0]   fifo_raddr_out,
    input logic [NUM_CH*12-1:0]  chan_status,
    input logic [TOP_W-1:0]      top_status
);
    localparam int FAULT_LSB = TOP_W - NUM_CH;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (rst)
            ((chan_status[c*12+10 -: 4] != 4'd0) || chan_status[c*12+3]) |=> top_status[FAULT_LSB+c]); // R3
        AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
            (top_status[FAULT_LSB+c] && !top_wr) |=> top_status[FAULT_LSB+c]); // R3
        AST_OFFLINE_ENTER: assert property (@(posedge clk) disable iff (rst)
            (fifo_ovf[c] && !ovf_halt_dis && !ch_rst[c]) |=> (fifo_raddr_out[c*3 +: 3] == 3'd0)); // R4
        AST_FORCED_ZERO: assert property (@(posedge clk) disable iff (rst)
            chan_status[c*12+3] |-> (chan_status[c*12+4 +: 3] == 3'd0)); // R5
        AST_FLUSH_OFFLINE: assert property (@(posedge clk) disable iff (rst)
            chan_status[c*12+11] |-> chan_status[c*12+3]); // R6
        AST_CHRST_CLEAR: assert property (@(posedge clk) disable iff (rst)
            ch_rst[c] |=> (chan_status[c*12 +: 12] == 12'd0)); // R7
    end

    for (genvar s = 0; s < NUM_SUM; s++) begin : g_s
        AST_SAT_LATCH: assert property (@(posedge clk) disable iff (rst)
            sum_sat[s] |=> top_status[s]); // R9
    end
endmodule

bind chfault_top chfault_top_chk #(
    .NUM_CH  (NUM_CH),
    .NUM_SUM (NUM_SUM),
    .TOP_W   (TOP_W)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .ovf_halt_dis   (ovf_halt_dis),
    .ch_rst         (ch_rst),
    .fifo_ovf       (fifo_ovf),
    .sum_sat        (sum_sat),
    .top_wr         (top_wr),
    .fifo_raddr_out (fifo_raddr_out),
    .chan_status    (chan_status),
    .top_status     (top_status)
);

// File: tb/chfault_top_tb_top.sv
`timescale 1ns/1ps
module chfault_top_tb_top;
    localparam int NCH = 4;
    localparam int NSUM = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sample_en = 1'b0;
    logic            ovf_halt_dis = 1'b0;
    logic [NCH-1:0]  ch_rst = '0;
    logic [NCH-1:0]  fir_ovf = '0, fir_unf = '0, fifo_ovf = '0, fifo_unf = '0;
    logic [NCH-1:0]  fifo_aempty = '0, fifo_empty = '0;
    logic [NCH*3-1:0] fifo_raddr_in = '0;
    logic [NSUM-1:0] sum_sat = '0;
    logic            top_wr = 1'b0;
    logic [NCH*3-1:0]  fifo_raddr_out;
    logic [NCH*12-1:0] chan_status;
    logic [15:0]       top_status;

    always #2.5 clk = ~clk;

    chfault_top dut_i (
        .clk(clk), .rst(rst), .sample_en(sample_en), .ovf_halt_dis(ovf_halt_dis),
        .ch_rst(ch_rst), .fir_ovf(fir_ovf), .fir_unf(fir_unf), .fifo_ovf(fifo_ovf),
        .fifo_unf(fifo_unf), .fifo_aempty(fifo_aempty), .fifo_empty(fifo_empty),
        .fifo_raddr_in(fifo_raddr_in), .sum_sat(sum_sat), .top_wr(top_wr),
        .fifo_raddr_out(fifo_raddr_out), .chan_status(chan_status), .top_status(top_status)
    );

    // Selectors: 0..3 channel status, 4 device word, 5..8 read address out
    typedef struct {
        string       req;
        int          sel;
        logic [15:0] val;
        int          due;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [11:0] mk_stat(logic fl, logic fo, logic fu, logic qo,
                                            logic qu, logic [2:0] ra, logic off,
                                            logic ae, logic em);
        return {fl, fo, fu, qo, qu, ra, off, ae, em, 1'b0};
    endfunction

    function automatic logic [15:0] act(int sel);
        if (sel < 4) return 16'(chan_status[sel*12 +: 12]);
        if (sel == 4) return top_status;
        return 16'(fifo_raddr_out[(sel-5)*3 +: 3]);
    endfunction

    // Expectation for the outputs seen after the next clock edge
    task automatic exp_next(string req, int sel, logic [15:0] val);
        exp_t e;
        e.req = req; e.sel = sel; e.val = val; e.due = cyc + 1;
        q.push_back(e);
    endtask

    task automatic step();
        @(posedge clk);
        #3;
    endtask

    // Monitor: compares between edges, away from any input change
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                logic [15:0] a;
                e = q.pop_front();
                a = act(e.sel);
                checks++;
                if (a !== e.val) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", e.req, e.sel, a, e.val);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        fifo_raddr_in[2:0] = 3'd5;
        step(); step();
        // R1: reset state
        exp_next("R1", 0, 16'h0000);
        exp_next("R1", 4, 16'h0000);
        exp_next("R1", 5, 16'd5);
        step();
        rst = 1'b0;

        // R2: capture layout
        fir_unf[1] = 1'b1; fifo_aempty[1] = 1'b1; fifo_raddr_in[5:3] = 3'd3;
        fifo_aempty[2] = 1'b1;
        exp_next("R2", 1, 16'(mk_stat(0,0,1,0,0,3'd3,0,1,0)));
        exp_next("R2", 0, 16'(mk_stat(0,0,0,0,0,3'd5,0,0,0)));
        exp_next("R2", 2, 16'(mk_stat(0,0,0,0,0,3'd0,0,1,0)));
        step();

        // R3: fault latch, sticky, almost-empty excluded
        fir_unf[1] = 1'b0; fifo_aempty[1] = 1'b0;
        exp_next("R3", 4, 16'h2000);
        step();
        exp_next("R3", 4, 16'h2000);
        exp_next("R2", 1, 16'(mk_stat(0,0,0,0,0,3'd3,0,0,0)));
        step();

        // R8: clear on write
        top_wr = 1'b1;
        exp_next("R8", 4, 16'h0000);
        step();
        top_wr = 1'b0; fifo_aempty[2] = 1'b0;

        // R8: cause present at clearing edge keeps the bit
        fir_ovf[3] = 1'b1;
        step();
        exp_next("R3", 4, 16'h8000);
        step();
        top_wr = 1'b1;
        exp_next("R8", 4, 16'h8000);
        step();
        fir_ovf[3] = 1'b0;
        step();
        exp_next("R8", 4, 16'h0000);
        step();
        top_wr = 1'b0;

        // R9: summer saturation sticky
        sum_sat[2] = 1'b1;
        exp_next("R9", 4, 16'h0004);
        step();
        sum_sat[2] = 1'b0;
        exp_next("R9", 4, 16'h0004);
        step();
        top_wr = 1'b1;
        exp_next("R9", 4, 16'h0000);
        step();
        top_wr = 1'b0;

        // R10: overflow with halt disabled keeps channel online
        ovf_halt_dis = 1'b1; fifo_ovf[0] = 1'b1;
        exp_next("R10", 0, 16'(mk_stat(0,0,0,1,0,3'd5,0,0,0)));
        exp_next("R10", 5, 16'd5);
        step();
        fifo_ovf[0] = 1'b0;
        exp_next("R10", 5, 16'd5);
        exp_next("R10", 0, 16'(mk_stat(0,0,0,0,0,3'd5,0,0,0)));
        step();
        ovf_halt_dis = 1'b0;
        step();
        top_wr = 1'b1;
        exp_next("R8", 4, 16'h0000);
        step();
        top_wr = 1'b0;

        // R4 / R5: overflow forces offline and zero address
        fifo_ovf[0] = 1'b1;
        exp_next("R4", 5, 16'd0);
        exp_next("R4", 0, 16'(mk_stat(0,0,0,1,0,3'd5,0,0,0)));
        step();
        fifo_ovf[0] = 1'b0;
        exp_next("R5", 0, 16'(mk_stat(0,0,0,0,0,3'd0,1,0,0)));
        exp_next("R5", 5, 16'd0);
        step();

        // R6: 23 counted pulses, then idle edges: not yet flushed
        sample_en = 1'b1;
        for (int i = 0; i < 23; i++) step();
        sample_en = 1'b0;
        exp_next("R6", 0, 16'(mk_stat(0,0,0,0,0,3'd0,1,0,0)));
        step(); step();
        exp_next("R6", 0, 16'(mk_stat(0,0,0,0,0,3'd0,1,0,0)));
        step();
        sample_en = 1'b1;
        step();
        sample_en = 1'b0;
        exp_next("R6", 0, 16'(mk_stat(1,0,0,0,0,3'd0,1,0,0)));
        step();

        // R7: persistence while offline
        sample_en = 1'b1; fifo_raddr_in[2:0] = 3'd6;
        for (int i = 0; i < 5; i++) step();
        sample_en = 1'b0;
        exp_next("R7", 0, 16'(mk_stat(1,0,0,0,0,3'd0,1,0,0)));
        exp_next("R7", 5, 16'd0);
        step();

        // R7: channel reset clears channel, not the device word
        ch_rst[0] = 1'b1;
        exp_next("R7", 0, 16'h0000);
        exp_next("R7", 5, 16'd6);
        exp_next("R7", 4, 16'h1000);
        step();
        ch_rst[0] = 1'b0;
        exp_next("R7", 0, 16'(mk_stat(0,0,0,0,0,3'd6,0,0,0)));
        exp_next("R7", 4, 16'h1000);
        step();
        step(); step();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule